// File: doc/BRIEF.md
# Register-Register ALU With Flags

This block is the arithmetic and logic unit for the two-register data-processing group of a compact 16-bit instruction encoding. It is purely combinational: a 4-bit sub-opcode selects one of sixteen operations that combine a destination operand and a source operand, and the block returns the 32-bit value, a strobe saying whether that value should be written back to the destination register, and the four condition flags (negative, zero, carry, overflow).

The incoming carry and overflow flags are inputs so that operations which leave a flag untouched can pass it straight through. Shift and rotate amounts are taken from the low byte of the source operand, never from an immediate. Three sub-opcodes (test, compare, compare-negative) only produce flags; the value is still presented on the result port but the write strobe is low. The register file, fetch and memory access live elsewhere.

Top module: `rr_alu`

## Requirements
- R1: The sub-opcode selects the operation as 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN; BIC gives dst AND NOT src and MVN gives NOT src.
- R2: TST (8), CMP (10) and CMN (11) present dst AND src, dst minus src and dst plus src on the result port, update the flags, and drive the write strobe low.
- R3: ADC gives dst + src + carry_in; SBC gives dst - src - (1 - carry_in); C is the carry out of the 32-bit addition (for subtraction, 1 means no borrow) and V is set when the signed result overflows.
- R4: NEG gives 0 - src with C and V set by the subtraction rules of R3.
- R5: LSL and LSR shift dst by src[7:0]; an amount of 32 or more gives zero, C is the last bit shifted out (0 once the amount exceeds 32).
- R6: ASR shifts dst right by src[7:0] filling with copies of bit 31; an amount of 32 or more gives all sign bits and C equal to bit 31.
- R7: ROR rotates dst right by src[7:0]; a non-zero multiple of 32 leaves the value and sets C to bit 31, otherwise C is the last bit rotated out.
- R8: For any shift or rotate with src[7:0] equal to zero the result equals dst and C equals carry_in, whatever src[31:8] holds.
- R9: For every sub-opcode N equals bit 31 of the result and Z is set exactly when the result is zero.
- R10: MUL gives the low 32 bits of dst times src and passes carry_in and ovf_in through to C and V.
- R11: AND, EOR, ORR, BIC, MVN and TST pass carry_in and ovf_in through to C and V; shifts and rotates pass ovf_in through to V.
- R12: The write strobe is high for every sub-opcode other than 8, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_val_i | input | 32 | Destination operand |
| src_val_i | input | 32 | Source operand; low byte is the shift amount |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| subop_i | input | 4 | Operation select |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Write the result back to the destination |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Flag production and write suppression fall on the same evaluation for the compare forms, so the bench feeds CMP and CMN operand pairs that give zero, borrow and signed overflow and judges the strobe low together with the exact Z, C and V it expects. The carry pass-through and a shift also coincide when a shift amount's low byte is zero but upper source bits are set; the bench sets carry_in both ways there and judges that the value and C are the untouched inputs. Every sub-opcode is also swept over a set of operand patterns against a bit-serial reference model.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_LSL = 4'd2,
        OP_LSR = 4'd3,
        OP_ASR = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_ROR = 4'd7,
        OP_TST = 4'd8,
        OP_NEG = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MUL = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } subop_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shkind_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              wr;
        logic              c;
        logic              v;
    } alu_out_t;

endpackage

// File: rtl/rr_adder.sv
module rr_adder #(
    parameter int W = rr_alu_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ov_o
);
    logic [W:0] wide_d;

    always_comb begin
        wide_d = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
        sum_o  = wide_d[W-1:0];
        co_o   = wide_d[W];
        ov_o   = (a_i[W-1] == b_i[W-1]) && (wide_d[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/rr_shifter.sv
module rr_shifter #(
    parameter int W   = rr_alu_pkg::DATA_W,
    parameter int AW  = rr_alu_pkg::AMT_W
) (
    input  rr_alu_pkg::shkind_e kind_i,
    input  logic [W-1:0]        val_i,
    input  logic [AW-1:0]       amt_i,
    input  logic                ci_i,
    output logic [W-1:0]        res_o,
    output logic                co_o
);
    import rr_alu_pkg::*;

    localparam int W2   = 2 * W;
    localparam int LOGW = $clog2(W);

    logic [W2-1:0]        ext_d;
    logic signed [W2-1:0] sext_d;
    logic [LOGW-1:0]      rot_d;
    logic                 below_w_d;
    logic                 at_w_d;

    always_comb begin
        below_w_d = (32'(amt_i) < W);
        at_w_d    = (32'(amt_i) == W);
        rot_d     = amt_i[LOGW-1:0];
        ext_d     = '0;
        sext_d    = '0;
        res_o     = val_i;
        co_o      = ci_i;
        if (amt_i != '0) begin
            unique case (kind_i)
                SH_LSL: begin
                    ext_d = {{W{1'b0}}, val_i} << amt_i;
                    if (below_w_d) begin
                        res_o = ext_d[W-1:0];
                        co_o  = ext_d[W];
                    end else begin
                        res_o = '0;
                        co_o  = at_w_d ? val_i[0] : 1'b0;
                    end
                end
                SH_LSR: begin
                    ext_d = {val_i, {W{1'b0}}} >> amt_i;
                    if (below_w_d) begin
                        res_o = ext_d[W2-1:W];
                        co_o  = ext_d[W-1];
                    end else begin
                        res_o = '0;
                        co_o  = at_w_d ? val_i[W-1] : 1'b0;
                    end
                end
                SH_ASR: begin
                    sext_d = $signed({val_i, {W{1'b0}}}) >>> amt_i;
                    if (below_w_d) begin
                        res_o = sext_d[W2-1:W];
                        co_o  = sext_d[W-1];
                    end else begin
                        res_o = {W{val_i[W-1]}};
                        co_o  = val_i[W-1];
                    end
                end
                SH_ROR: begin
                    ext_d = {val_i, val_i} >> rot_d;
                    res_o = ext_d[W-1:0];
                    co_o  = ext_d[W-1];
                end
                default: begin
                    res_o = val_i;
                    co_o  = ci_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/rr_nz_flags.sv
module rr_nz_flags #(
    parameter int W = rr_alu_pkg::DATA_W
) (
    input  logic [W-1:0] val_i,
    output logic         n_o,
    output logic         z_o
);
    always_comb begin
        n_o = val_i[W-1];
        z_o = ~|val_i;
    end
endmodule

// File: rtl/rr_alu.sv
module rr_alu (
    input  logic [31:0] dst_val_i,
    input  logic [31:0] src_val_i,
    input  logic        carry_i,
    input  logic        ovf_i,
    input  logic [3:0]  subop_i,
    output logic [31:0] result_o,
    output logic        wr_en_o,
    output logic        flag_n_o,
    output logic        flag_z_o,
    output logic        flag_c_o,
    output logic        flag_v_o
);
    import rr_alu_pkg::*;

    localparam int W  = DATA_W;
    localparam int AW = AMT_W;

    subop_e      op_d;
    logic [W-1:0] add_a_d;
    logic [W-1:0] add_b_d;
    logic         add_ci_d;
    logic [W-1:0] add_sum;
    logic         add_co;
    logic         add_ov;
    shkind_e      sh_kind_d;
    logic [W-1:0] sh_res;
    logic         sh_co;
    logic [W-1:0] prod_d;
    alu_out_t     res_d;
    logic         n_flag;
    logic         z_flag;

    // operand steering for the shared adder and the shifter
    always_comb begin
        op_d      = subop_e'(subop_i);
        add_a_d   = dst_val_i;
        add_b_d   = src_val_i;
        add_ci_d  = 1'b0;
        sh_kind_d = SH_LSL;
        unique case (op_d)
            OP_ADC: add_ci_d = carry_i;
            OP_SBC: begin
                add_b_d  = ~src_val_i;
                add_ci_d = carry_i;
            end
            OP_CMP: begin
                add_b_d  = ~src_val_i;
                add_ci_d = 1'b1;
            end
            OP_NEG: begin
                add_a_d  = '0;
                add_b_d  = ~src_val_i;
                add_ci_d = 1'b1;
            end
            OP_LSR:  sh_kind_d = SH_LSR;
            OP_ASR:  sh_kind_d = SH_ASR;
            OP_ROR:  sh_kind_d = SH_ROR;
            default: ;
        endcase
    end

    rr_adder #(.W(W)) adder_i (
        .a_i   (add_a_d),
        .b_i   (add_b_d),
        .ci_i  (add_ci_d),
        .sum_o (add_sum),
        .co_o  (add_co),
        .ov_o  (add_ov)
    );

    rr_shifter #(.W(W), .AW(AW)) shifter_i (
        .kind_i (sh_kind_d),
        .val_i  (dst_val_i),
        .amt_i  (src_val_i[AW-1:0]),
        .ci_i   (carry_i),
        .res_o  (sh_res),
        .co_o   (sh_co)
    );

    // result, write strobe and carry/overflow selection
    always_comb begin
        prod_d    = dst_val_i * src_val_i;
        res_d.wr  = 1'b1;
        res_d.c   = carry_i;
        res_d.v   = ovf_i;
        res_d.value = '0;
        unique case (op_d)
            OP_AND: res_d.value = dst_val_i & src_val_i;
            OP_EOR: res_d.value = dst_val_i ^ src_val_i;
            OP_ORR: res_d.value = dst_val_i | src_val_i;
            OP_BIC: res_d.value = dst_val_i & ~src_val_i;
            OP_MVN: res_d.value = ~src_val_i;
            OP_MUL: res_d.value = prod_d;
            OP_TST: begin
                res_d.value = dst_val_i & src_val_i;
                res_d.wr    = 1'b0;
            end
            OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
                res_d.value = sh_res;
                res_d.c     = sh_co;
            end
            OP_ADC, OP_SBC, OP_NEG: begin
                res_d.value = add_sum;
                res_d.c     = add_co;
                res_d.v     = add_ov;
            end
            OP_CMP, OP_CMN: begin
                res_d.value = add_sum;
                res_d.c     = add_co;
                res_d.v     = add_ov;
                res_d.wr    = 1'b0;
            end
            default: ;
        endcase
    end

    rr_nz_flags #(.W(W)) nz_i (
        .val_i (res_d.value),
        .n_o   (n_flag),
        .z_o   (z_flag)
    );

    assign result_o = res_d.value;
    assign wr_en_o  = res_d.wr;
    assign flag_c_o = res_d.c;
    assign flag_v_o = res_d.v;
    assign flag_n_o = n_flag;
    assign flag_z_o = z_flag;

endmodule

// File: rtl/rr_alu_chk.sv
module rr_alu_chk (
    input logic [31:0] dst_val_i,
    input logic [31:0] src_val_i,
    input logic        carry_i,
    input logic        ovf_i,
    input logic [3:0]  subop_i,
    input logic [31:0] result_o,
    input logic        wr_en_o,
    input logic        flag_n_o,
    input logic        flag_z_o,
    input logic        flag_c_o,
    input logic        flag_v_o
);
    logic flag_only;
    logic logic_op;
    logic shift_op;

    always_comb begin
        flag_only = (subop_i == 4'd8) || (subop_i == 4'd10) || (subop_i == 4'd11);
        logic_op  = (subop_i == 4'd0) || (subop_i == 4'd1) || (subop_i == 4'd8)
                 || (subop_i == 4'd12) || (subop_i == 4'd14) || (subop_i == 4'd15);
        shift_op  = (subop_i == 4'd2) || (subop_i == 4'd3) || (subop_i == 4'd4)
                 || (subop_i == 4'd7);

        // R2
        no_write_on_compare_chk: assert (!(flag_only && wr_en_o))
            else $error("compare form raised write strobe");
        // R12
        write_on_others_chk: assert (flag_only || wr_en_o)
            else $error("write strobe low on a writing op");
        // R9
        n_follows_msb_chk: assert (flag_n_o == result_o[31])
            else $error("N does not follow result bit 31");
        // R9
        z_follows_zero_chk: assert (flag_z_o == (result_o == 32'd0))
            else $error("Z does not match zero result");
        // R10
        mul_keeps_cv_chk: assert (!(subop_i == 4'd13) || (flag_c_o == carry_i && flag_v_o == ovf_i))
            else $error("MUL altered C or V");
        // R11
        logic_keeps_cv_chk: assert (!logic_op || (flag_c_o == carry_i && flag_v_o == ovf_i))
            else $error("logic op altered C or V");
        // R8
        zero_shift_passes_chk: assert (!(shift_op && src_val_i[7:0] == 8'd0)
                                       || (result_o == dst_val_i && flag_c_o == carry_i))
            else $error("zero shift changed value or carry");
    end
endmodule

bind rr_alu rr_alu_chk chk_i (.*);

// File: tb/rr_alu_tb_top.sv
module rr_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk;
    logic [31:0] dst_val;
    logic [31:0] src_val;
    logic        carry_in;
    logic        ovf_in;
    logic [3:0]  subop;
    logic [31:0] result;
    logic        wr_en;
    logic        fn, fz, fc, fv;

    int n_checks;
    int n_fails;
    bit done;

    rr_alu dut_i (
        .dst_val_i (dst_val),
        .src_val_i (src_val),
        .carry_i   (carry_in),
        .ovf_i     (ovf_in),
        .subop_i   (subop),
        .result_o  (result),
        .wr_en_o   (wr_en),
        .flag_n_o  (fn),
        .flag_z_o  (fz),
        .flag_c_o  (fc),
        .flag_v_o  (fv)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // bit-serial reference: value, wr, n, z, c, v packed as {v,c,z,n,wr,value}
    function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] d,
                                          input logic [31:0] s, input logic ci, input logic vi);
        logic [31:0] r;
        logic [32:0] w;
        logic        c;
        logic        v;
        logic        wr;
        logic [31:0] x;
        int          amt;
        r  = 32'd0;
        c  = ci;
        v  = vi;
        wr = !(op == 4'd8 || op == 4'd10 || op == 4'd11);
        amt = int'(s[7:0]);
        x  = d;
        case (op)
            4'd0, 4'd8: r = d & s;
            4'd1:  r = d ^ s;
            4'd12: r = d | s;
            4'd14: r = d & ~s;
            4'd15: r = ~s;
            4'd13: r = 32'(64'(d) * 64'(s));
            4'd2: begin
                for (int i = 0; i < amt; i++) begin c = x[31]; x = x << 1; end
                r = x;
            end
            4'd3: begin
                for (int i = 0; i < amt; i++) begin c = x[0]; x = x >> 1; end
                r = x;
            end
            4'd4: begin
                for (int i = 0; i < amt; i++) begin c = x[0]; x = {x[31], x[31:1]}; end
                r = x;
            end
            4'd7: begin
                for (int i = 0; i < amt; i++) begin c = x[0]; x = {x[0], x[31:1]}; end
                r = x;
            end
            4'd5, 4'd11: begin
                w = 33'(d) + 33'(s) + ((op == 4'd5) ? 33'(ci) : 33'd0);
                r = w[31:0]; c = w[32];
                v = (d[31] == s[31]) && (r[31] != d[31]);
            end
            default: begin // 6 SBC, 9 NEG, 10 CMP: a - b - borrow
                logic [31:0] a;
                logic        nb;
                a  = (op == 4'd9) ? 32'd0 : d;
                nb = (op == 4'd6) ? ci : 1'b1;
                w = 33'(a) - 33'(s) - 33'(!nb);
                r = w[31:0];
                c = !w[32];
                v = (a[31] != s[31]) && (r[31] != a[31]);
            end
        endcase
        return {v, c, (r == 32'd0), r[31], wr, r};
    endfunction

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [3:0] op, input logic [31:0] d,
                       input logic [31:0] s, input logic ci, input logic vi);
        logic [36:0] e;
        @(posedge clk);
        #1;
        subop = op; dst_val = d; src_val = s; carry_in = ci; ovf_in = vi;
        @(negedge clk);
        e = model(op, d, s, ci, vi);
        n_checks++;
        if (result !== e[31:0]) begin
            n_fails++;
            $display("FAIL %s op%0d result: actual %h expected %h", req, op, result, e[31:0]);
        end
        check_bit(req, "wr", wr_en, e[32]);
        check_bit(req, "N",  fn,    e[33]);
        check_bit(req, "Z",  fz,    e[34]);
        check_bit(req, "C",  fc,    e[35]);
        check_bit(req, "V",  fv,    e[36]);
    endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fails++;
            $display("FAIL %s fixed result: actual %h expected %h", req, result, exp);
        end
    endtask

    task automatic t_zero_state();
        run("R9", 4'd0, 32'd0, 32'd0, 1'b0, 1'b0);
        check_bit("R9", "Z on zero AND", fz, 1'b1);
    endtask

    task automatic t_logic_r1_r11();
        run("R1", 4'd0, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 1'b0);
        expect_word("R1", 32'h00F0_1200);
        run("R1", 4'd1, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b1);
        run("R1", 4'd12, 32'h8000_0001, 32'h0000_0100, 1'b1, 1'b1);
        run("R1", 4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0);
        expect_word("R1", 32'hFFFF_0000);
        run("R1", 4'd15, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 1'b0);
        expect_word("R1", 32'h0000_0000);
        run("R11", 4'd1, 32'h1, 32'h1, 1'b1, 1'b1);
        check_bit("R11", "C kept", fc, 1'b1);
        check_bit("R11", "V kept", fv, 1'b1);
    endtask

    task automatic t_compare_r2();
        run("R2", 4'd10, 32'd5, 32'd5, 1'b0, 1'b1);
        check_bit("R2", "CMP equal wr", wr_en, 1'b0);
        check_bit("R2", "CMP equal Z", fz, 1'b1);
        check_bit("R2", "CMP equal C", fc, 1'b1);
        run("R2", 4'd10, 32'd3, 32'd7, 1'b1, 1'b0);
        check_bit("R2", "CMP borrow C", fc, 1'b0);
        run("R2", 4'd10, 32'h8000_0000, 32'd1, 1'b0, 1'b0);
        check_bit("R2", "CMP ovf V", fv, 1'b1);
        run("R2", 4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
        check_bit("R2", "CMN wrap Z", fz, 1'b1);
        check_bit("R2", "CMN wrap C", fc, 1'b1);
        run("R2", 4'd8, 32'hF0, 32'h0F, 1'b1, 1'b1);
        check_bit("R2", "TST wr", wr_en, 1'b0);
    endtask

    task automatic t_addsub_r3_r4();
        run("R3", 4'd5, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0);
        check_bit("R3", "ADC carry chain", fc, 1'b1);
        run("R3", 4'd5, 32'h7FFF_FFFF, 32'd0, 1'b1, 1'b0);
        check_bit("R3", "ADC overflow", fv, 1'b1);
        run("R3", 4'd6, 32'd10, 32'd3, 1'b1, 1'b0);
        expect_word("R3", 32'd7);
        run("R3", 4'd6, 32'd10, 32'd3, 1'b0, 1'b0);
        expect_word("R3", 32'd6);
        run("R4", 4'd9, 32'hDEAD_BEEF, 32'd1, 1'b0, 1'b0);
        expect_word("R4", 32'hFFFF_FFFF);
        run("R4", 4'd9, 32'd0, 32'd0, 1'b0, 1'b1);
        check_bit("R4", "NEG 0 carry", fc, 1'b1);
        run("R4", 4'd9, 32'd0, 32'h8000_0000, 1'b0, 1'b0);
        check_bit("R4", "NEG min V", fv, 1'b1);
    endtask

    task automatic t_shifts_r5_r6_r7_r8();
        run("R5", 4'd2, 32'h8000_0003, 32'd1, 1'b0, 1'b1);
        check_bit("R5", "LSL1 C", fc, 1'b1);
        run("R5", 4'd2, 32'h0000_0001, 32'd32, 1'b0, 1'b0);
        check_bit("R5", "LSL32 C", fc, 1'b1);
        run("R5", 4'd2, 32'hFFFF_FFFF, 32'd33, 1'b1, 1'b0);
        expect_word("R5", 32'd0);
        run("R5", 4'd3, 32'h8000_0000, 32'd31, 1'b0, 1'b0);
        expect_word("R5", 32'd1);
        run("R5", 4'd3, 32'h8000_0000, 32'd32, 1'b0, 1'b0);
        run("R5", 4'd3, 32'hFFFF_FFFF, 32'd200, 1'b1, 1'b0);
        run("R6", 4'd4, 32'h8000_0000, 32'd4, 1'b0, 1'b0);
        expect_word("R6", 32'hF800_0000);
        run("R6", 4'd4, 32'h8000_0000, 32'd40, 1'b0, 1'b0);
        expect_word("R6", 32'hFFFF_FFFF);
        run("R6", 4'd4, 32'h4000_0000, 32'd255, 1'b1, 1'b0);
        run("R7", 4'd7, 32'h0000_0001, 32'd1, 1'b0, 1'b0);
        expect_word("R7", 32'h8000_0000);
        run("R7", 4'd7, 32'h8000_1234, 32'd64, 1'b0, 1'b0);
        check_bit("R7", "ROR64 C", fc, 1'b1);
        run("R7", 4'd7, 32'h1234_5678, 32'd36, 1'b1, 1'b0);
        for (int k = 2; k <= 7; k++) begin
            if (k == 5 || k == 6) continue;
            run("R8", 4'(k), 32'hC001_D00D, 32'hFFFF_FF00, 1'b1, 1'b0);
            expect_word("R8", 32'hC001_D00D);
            check_bit("R8", "zero-amount C", fc, 1'b1);
            run("R8", 4'(k), 32'h0000_0001, 32'h0000_0100, 1'b0, 1'b1);
            check_bit("R8", "zero-amount C low", fc, 1'b0);
        end
    endtask

    task automatic t_mul_r10();
        run("R10", 4'd13, 32'h0001_0000, 32'h0001_0000, 1'b1, 1'b1);
        expect_word("R10", 32'd0);
        check_bit("R10", "MUL C kept", fc, 1'b1);
        check_bit("R10", "MUL V kept", fv, 1'b1);
        run("R10", 4'd13, 32'hFFFF_FFFF, 32'd3, 1'b0, 1'b0);
        expect_word("R10", 32'hFFFF_FFFD);
    endtask

    task automatic t_sweep_r12();
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
        pats[3] = 32'h7FFF_FFFF; pats[4] = 32'h0000_0021; pats[5] = 32'h5A5A_A5A5;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 6; a++) begin
                for (int b = 0; b < 6; b++) begin
                    run("R12", 4'(op), pats[a], pats[b], 1'(a + b), 1'(a));
                end
            end
        end
    endtask

    initial begin
        n_checks = 0; n_fails = 0; done = 1'b0;
        dst_val = '0; src_val = '0; carry_in = 1'b0; ovf_in = 1'b0; subop = '0;
        t_zero_state();
        t_logic_r1_r11();
        t_compare_r2();
        t_addsub_r3_r4();
        t_shifts_r5_r6_r7_r8();
        t_mul_r10();
        t_sweep_r12();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule